// File: doc/BRIEF.md
# SPI Master with Independent Transmit and Receive Byte Counts

This block drives one SPI bus transaction each time it receives a start pulse. Two separate byte counts are loaded at start: how many bytes to send and how many bytes to keep. The bus runs for whichever count is larger. Once the transmit count is used up, the block sends a filler byte taken from configuration. Once the receive count is reached, it drops the bytes it clocks in. A transmit count of zero gives a pure read, and a receive count of zero gives a pure write.

Transmit bytes are fetched through a one-cycle request: `tx_data` must be valid in the same cycle that `tx_req` is high. Each kept byte is presented for one cycle on `rx_valid`/`rx_data`. The clock divider, polarity, phase, bit order and filler byte are configuration inputs and are captured at start. The block has two sticky events, started and end. Each event can drive the interrupt through an enable register that has separate set and clear ports.

The controller is a four-state machine:
- IDLE to LOAD on an accepted start with a non-zero length.
- IDLE to DONE on an accepted start with zero length.
- LOAD to SHIFT always, after fetching the next byte or the filler.
- SHIFT to LOAD after the 16th half-period of a byte that is not the last one.
- SHIFT to DONE after the 16th half-period of the last byte.
- DONE to IDLE always, raising the end event.

Top module: `spi_byte_master`

## Requirements
- R1: Bus length. The number of bytes clocked equals max(tx_count, rx_count), both captured at start.
- R2: Filler. Bus byte i, counted from 0, carries transmit byte i when i < tx_count, and otherwise carries `cfg_filler`.
- R3: Receive limit. Only bytes with index < rx_count are presented on `rx_valid`, in order. `rx_valid` is high only while `busy` is high. A receive count of zero presents nothing.
- R4: Mode mapping. `cfg_cpol`=0 idles SCK low and `cfg_cpol`=1 idles it high. `cfg_cpha`=0 samples MISO on the leading SCK edge and changes MOSI on the trailing edge. `cfg_cpha`=1 changes MOSI on the leading edge and samples on the trailing edge. Modes 0 to 3 are {cpol,cpha} = 00, 01, 10, 11.
- R5: Bit order. `cfg_lsb_first`=0 shifts bit 7 first and `cfg_lsb_first`=1 shifts bit 0 first, for both MOSI and MISO.
- R6: Idle levels. While IDLE, both `sck` and `mosi` equal `cfg_cpol`.
- R7: Events. `evt_started` is set in the cycle after an accepted start. `evt_end` is set in the same cycle that `busy` falls. Each stays set until its clear input is pulsed.
- R8: Interrupt. The enable bits are bit 0 for started and bit 1 for end. Bits are set through `irq_en_set` and cleared through `irq_en_clr`, and clear wins when both are given. `irq` is the OR of events whose enable bit is set. Writing 2'b11 to the clear port drops `irq` the next cycle.
- R9: Clock rate. Each SCK half-period lasts `cfg_div`+1 clock cycles. The divider is captured at start, so a later change has no effect on the running transaction.
- R10: Busy. `busy` is high for exactly N·(16·(div+1)+1)+1 cycles, where N is the bus length. A start that arrives while busy is ignored.
- R11: Transmit fetch. `tx_req` pulses exactly tx_count times per transaction, once before each transmitted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Half-period divider minus one |
| cfg_cpol | input | 1 | Clock polarity (idle level) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_filler | input | 8 | Byte sent after transmit data runs out |
| tx_count | input | CNT_W | Bytes to transmit |
| rx_count | input | CNT_W | Bytes to keep |
| start | input | 1 | Start request pulse |
| tx_req | output | 1 | Transmit byte fetch strobe |
| tx_data | input | 8 | Transmit byte, valid while tx_req is high |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transaction in progress |
| evt_started | output | 1 | Sticky started event |
| evt_end | output | 1 | Sticky end event |
| evt_started_clr | input | 1 | Clears the started event |
| evt_end_clr | input | 1 | Clears the end event |
| irq_en_set | input | 2 | Interrupt enable set port |
| irq_en_clr | input | 2 | Interrupt enable clear port |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts `busy` cycles at each falling clock edge and compares the total with N·(16·(div+1)+1)+1. It also measures the first active SCK phase in absolute time against (div+1) clock periods. `rx_valid` arrives one cycle after the final half-period of a kept byte, still inside `busy`, and a falling-edge monitor pops the expected byte there. The slave model samples MOSI only on the edge the mode calls for, which is well after the register that changed it. Events and `irq` are read one full cycle after the stimulus that sets or clears them.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } bm_state_e;

    localparam int EV_STARTED = 0;
    localparam int EV_END     = 1;
    localparam int EV_NUM     = 2;
    localparam int HALVES     = 16;
endpackage

// File: rtl/spi_bm_halftick.sv
module spi_bm_halftick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R9: with a non-zero divider two ticks are never adjacent
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && run) |=> !tick);
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lsb_first,
    input  logic       load,
    input  logic       load_emit,
    input  logic [7:0] load_byte,
    input  logic       idle_lvl,
    input  logic       emit,
    input  logic       sample,
    input  logic       miso,
    output logic       bit_q,
    output logic [7:0] rx_cur,
    output logic [7:0] rx_next
);
    logic [7:0] sr;

    function automatic logic pick(input logic [7:0] b, input logic lsb);
        return lsb ? b[0] : b[7];
    endfunction

    function automatic logic [7:0] adv(input logic [7:0] b, input logic lsb);
        return lsb ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
    endfunction

    assign rx_next = lsb_first ? {miso, rx_cur[7:1]} : {rx_cur[6:0], miso};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            bit_q <= 1'b0;
        end else if (load) begin
            sr    <= load_emit ? adv(load_byte, lsb_first) : load_byte;
            bit_q <= load_emit ? pick(load_byte, lsb_first) : idle_lvl;
        end else if (emit) begin
            sr    <= adv(sr, lsb_first);
            bit_q <= pick(sr, lsb_first);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_cur <= '0;
        else if (sample)
            rx_cur <= rx_next;
    end
endmodule

// File: rtl/spi_bm_events.sv
module spi_bm_events
    import spi_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_NUM-1:0] ev_set,
    input  logic [EV_NUM-1:0] ev_clr,
    input  logic [EV_NUM-1:0] en_set,
    input  logic [EV_NUM-1:0] en_clr,
    output logic [EV_NUM-1:0] ev,
    output logic              irq
);
    logic [EV_NUM-1:0] en;

    generate
        for (genvar i = 0; i < EV_NUM; i++) begin : g_ev
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ev[i] <= 1'b0;
                    en[i] <= 1'b0;
                end else begin
                    ev[i] <= ev_set[i] | (ev[i] & ~ev_clr[i]);
                    en[i] <= (en[i] | en_set[i]) & ~en_clr[i];
                end
            end

            // R7: an event stays pending until cleared
            p_evt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ev[i] && !ev_clr[i]) |=> ev[i]);
        end
    endgenerate

    assign irq = |(ev & en);

    // R8: clearing every enable silences the interrupt next cycle
    p_irq_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr == '1) |=> !irq);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [7:0]       cfg_filler,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             start,
    output logic             tx_req,
    input  logic [7:0]       tx_data,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             evt_started,
    output logic             evt_end,
    input  logic             evt_started_clr,
    input  logic             evt_end_clr,
    input  logic [1:0]       irq_en_set,
    input  logic [1:0]       irq_en_clr,
    output logic             irq
);
    localparam int HW = $clog2(HALVES);
    localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

    bm_state_e        state, nxt;
    logic [DIV_W-1:0] div_q;
    logic             cpol_q, cpha_q, lsb_q;
    logic [7:0]       filler_q;
    logic [CNT_W-1:0] txc_q, rxc_q, len_q, idx;
    logic [CNT_W-1:0] len_in;
    logic [HW-1:0]    half;
    logic             sck_q;
    logic             tick, run, start_ok, byte_end, last_byte;
    logic             emit, sample, load, load_emit;
    logic [7:0]       load_byte, rx_cur, rx_next;
    logic             bit_q;
    logic [EV_NUM-1:0] ev, ev_set, ev_clr;

    assign len_in    = (tx_count > rx_count) ? tx_count : rx_count;
    assign start_ok  = (state == ST_IDLE) && start;
    assign run       = (state == ST_SHIFT);
    assign byte_end  = run && tick && (half == LAST_HALF);
    assign last_byte = (idx == len_q - 1'b1);

    // next-state process
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (len_in == '0) ? ST_DONE : ST_LOAD;
            ST_LOAD:  nxt = ST_SHIFT;
            ST_SHIFT: if (byte_end) nxt = last_byte ? ST_DONE : ST_LOAD;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // output / datapath process
    always_comb begin
        busy      = (state != ST_IDLE);
        load      = (state == ST_LOAD);
        tx_req    = load && (idx < txc_q);
        load_byte = tx_req ? tx_data : filler_q;
        load_emit = load && !cpha_q;
        emit      = run && tick && (cpha_q ? !half[0] : (half[0] && half != LAST_HALF));
        sample    = run && tick && (cpha_q ? half[0] : !half[0]);
        unique case (state)
            ST_IDLE: begin
                sck  = cfg_cpol;
                mosi = cfg_cpol;
            end
            ST_DONE: begin
                sck  = sck_q;
                mosi = cpol_q;
            end
            default: begin
                sck  = sck_q;
                mosi = bit_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            lsb_q    <= 1'b0;
            filler_q <= '0;
            txc_q    <= '0;
            rxc_q    <= '0;
            len_q    <= '0;
            idx      <= '0;
            half     <= '0;
            sck_q    <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sck_q <= cfg_cpol;
                    if (start) begin
                        div_q    <= cfg_div;
                        cpol_q   <= cfg_cpol;
                        cpha_q   <= cfg_cpha;
                        lsb_q    <= cfg_lsb_first;
                        filler_q <= cfg_filler;
                        txc_q    <= tx_count;
                        rxc_q    <= rx_count;
                        len_q    <= len_in;
                        idx      <= '0;
                    end
                end
                ST_LOAD: half <= '0;
                ST_SHIFT: begin
                    if (tick) begin
                        sck_q <= ~sck_q;
                        half  <= half + 1'b1;
                    end
                    if (byte_end) begin
                        idx      <= idx + 1'b1;
                        rx_valid <= (idx < rxc_q);
                        rx_data  <= cpha_q ? rx_next : rx_cur;
                    end
                end
                ST_DONE: sck_q <= cpol_q;
                default: ;
            endcase
        end
    end

    spi_bm_halftick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    spi_bm_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .lsb_first(lsb_q),
        .load     (load),
        .load_emit(load_emit),
        .load_byte(load_byte),
        .idle_lvl (cpol_q),
        .emit     (emit),
        .sample   (sample),
        .miso     (miso),
        .bit_q    (bit_q),
        .rx_cur   (rx_cur),
        .rx_next  (rx_next)
    );

    assign ev_set[EV_STARTED] = start_ok;
    assign ev_set[EV_END]     = (state == ST_DONE);
    assign ev_clr[EV_STARTED] = evt_started_clr;
    assign ev_clr[EV_END]     = evt_end_clr;

    spi_bm_events u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_set(ev_set),
        .ev_clr(ev_clr),
        .en_set(irq_en_set),
        .en_clr(irq_en_clr),
        .ev    (ev),
        .irq   (irq)
    );

    assign evt_started = ev[EV_STARTED];
    assign evt_end     = ev[EV_END];

    // R7: the end event is pending when busy drops
    p_end_at_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt_end);

    // R10: a new started event only appears inside a transaction
    p_started_in_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_started) |-> busy);

    // R3: received bytes are only presented while busy
    p_rx_in_txn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R9: SCK holds between half-period ticks while shifting
    p_sck_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && nxt == ST_SHIFT) |=> $stable(sck));
endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [7:0]       cfg_filler = 8'h00;
    logic [CNT_W-1:0] tx_count = '0, rx_count = '0;
    logic             start = 1'b0;
    logic             tx_req, rx_valid, sck, mosi, busy, evt_started, evt_end, irq;
    logic [7:0]       tx_data, rx_data;
    logic             miso = 1'b0;
    logic             evt_started_clr = 1'b0, evt_end_clr = 1'b0;
    logic [1:0]       irq_en_set = '0, irq_en_clr = '0;

    int n_checks = 0, n_fail = 0;
    int tx_idx = 0, tx_base = 0;
    bit cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
    int cur_div = 0;
    logic [7:0] mosi_q[$];
    logic [7:0] rx_q[$];
    bit done_flag = 0;

    function automatic logic [7:0] tx_pat(input int i);
        return 8'h3C ^ 8'(i * 29);
    endfunction

    function automatic logic [7:0] miso_pat(input int i);
        return 8'hC3 + 8'(i * 17);
    endfunction

    assign tx_data = tx_pat(tx_idx - tx_base);

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_byte_master #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_filler(cfg_filler),
        .tx_count(tx_count), .rx_count(rx_count), .start(start), .tx_req(tx_req),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck),
        .mosi(mosi), .miso(miso), .busy(busy), .evt_started(evt_started),
        .evt_end(evt_end), .evt_started_clr(evt_started_clr),
        .evt_end_clr(evt_end_clr), .irq_en_set(irq_en_set),
        .irq_en_clr(irq_en_clr), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // transmit source model
    always @(posedge clk) if (tx_req) tx_idx <= tx_idx + 1;

    // SPI slave model
    int  s_pos = 0, s_nbits = 0;
    logic [7:0] s_byte = '0;
    time t_lead = 0;
    bit  first_pulse = 0;

    function automatic logic mbit(input int p);
        logic [7:0] b;
        int j;
        b = miso_pat(p / 8);
        j = p % 8;
        return cur_lsb ? b[j] : b[7 - j];
    endfunction

    always @(posedge busy) begin
        s_pos = 0;
        s_nbits = 0;
        first_pulse = 1;
        if (!cur_cpha) begin
            miso = mbit(0);
            s_pos = 1;
        end
    end

    always @(sck) begin
        if (busy) begin
            bit lead;
            lead = (sck != cur_cpol);
            if (lead) t_lead = $time;
            else if (first_pulse) begin
                first_pulse = 0;
                // R9: active phase lasts div+1 clocks
                chk(($time - t_lead) == (cur_div + 1) * CLK_PERIOD, "R9 half-period",
                    int'($time - t_lead), (cur_div + 1) * CLK_PERIOD);
            end
            if (lead != cur_cpha) begin
                s_byte = cur_lsb ? {mosi, s_byte[7:1]} : {s_byte[6:0], mosi};
                s_nbits++;
                if (s_nbits == 8) begin
                    s_nbits = 0;
                    if (mosi_q.size() == 0)
                        chk(0, "R1 extra bus byte", s_byte, 0);
                    else begin
                        logic [7:0] e;
                        e = mosi_q.pop_front();
                        // R2 R4 R5: MOSI byte content, edge and order
                        chk(s_byte == e, "R2/R4/R5 mosi byte", s_byte, e);
                    end
                end
            end else begin
                miso = mbit(s_pos);
                s_pos++;
            end
        end
    end

    // receive monitor (scoreboard)
    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_q.size() == 0)
                chk(0, "R3 unexpected rx byte", rx_data, 0);
            else begin
                logic [7:0] e;
                e = rx_q.pop_front();
                chk(rx_data == e, "R3/R4/R5 rx byte", rx_data, e);
            end
        end
    end

    task automatic run_txn(input int txc, input int rxc, input bit cpol, input bit cpha,
                           input bit lsb, input int dv, input logic [7:0] fill,
                           input bit poke);
        int n, cnt, tx0;
        @(negedge clk);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_div = DIV_W'(dv); cfg_filler = fill;
        tx_count = CNT_W'(txc); rx_count = CNT_W'(rxc);
        cur_cpol = cpol; cur_cpha = cpha; cur_lsb = lsb; cur_div = dv;
        n = (txc > rxc) ? txc : rxc;
        for (int i = 0; i < n; i++) mosi_q.push_back(i < txc ? tx_pat(i) : fill);
        for (int i = 0; i < rxc; i++) rx_q.push_back(miso_pat(i));
        tx_base = tx_idx;
        tx0 = tx_idx;
        repeat (2) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        cnt = 0;
        while (busy && cnt < 20000) begin
            cnt++;
            if (poke && cnt == 20) begin start = 1; cfg_div = '0; end
            if (poke && cnt == 21) start = 0;
            @(negedge clk);
        end
        start = 0;
        cfg_div = DIV_W'(dv);
        // R10: busy length; stray start has no effect
        chk(cnt == n * (16 * (dv + 1) + 1) + 1, "R10 busy cycles", cnt,
            n * (16 * (dv + 1) + 1) + 1);
        chk((tx_idx - tx0) == txc, "R11 tx_req count", tx_idx - tx0, txc);
        chk(mosi_q.size() == 0, "R1 bus byte count", mosi_q.size(), 0);
        chk(rx_q.size() == 0, "R3 rx byte count", rx_q.size(), 0);
        chk(evt_started == 1'b1, "R7 started event", evt_started, 1);
        chk(evt_end == 1'b1, "R7 end event", evt_end, 1);
        // R6: idle levels follow polarity
        chk(sck == cpol && mosi == cpol, "R6 idle levels", {sck, mosi}, {cpol, cpol});
        mosi_q.delete();
        rx_q.delete();
    endtask

    task automatic clear_events();
        evt_started_clr = 1; evt_end_clr = 1;
        @(negedge clk);
        evt_started_clr = 0; evt_end_clr = 0;
        @(negedge clk);
        chk(!evt_started && !evt_end, "R7 events cleared", {evt_started, evt_end}, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !sck && !mosi && !evt_started && !evt_end && !irq && !tx_req && !rx_valid,
            "R6/R7 reset state", {busy, sck, mosi, evt_started, evt_end, irq}, 0);

        // enable only the end interrupt
        irq_en_set = 2'b10;
        @(negedge clk);
        irq_en_set = 2'b00;

        run_txn(3, 3, 0, 0, 0, 1, 8'h00, 0);          // mode 0, msb first
        chk(irq == 1'b1, "R8 end irq enabled", irq, 1);
        irq_en_clr = 2'b11;
        @(negedge clk);
        irq_en_clr = 2'b00;
        chk(irq == 1'b0 && evt_end, "R8 clear all enables", irq, 0);
        clear_events();

        run_txn(2, 4, 0, 1, 1, 0, 8'h5A, 0);          // mode 1, lsb first, filler
        chk(irq == 1'b0, "R8 irq stays disabled", irq, 0);
        clear_events();

        run_txn(4, 1, 1, 0, 0, 2, 8'h00, 0);          // mode 2, rx dropped
        clear_events();

        irq_en_set = 2'b01;                           // started interrupt only
        @(negedge clk);
        irq_en_set = 2'b00;
        run_txn(0, 3, 1, 1, 1, 1, 8'hE7, 0);          // mode 3, read-only
        chk(irq == 1'b1, "R8 started irq", irq, 1);
        evt_started_clr = 1;
        @(negedge clk);
        evt_started_clr = 0;
        @(negedge clk);
        chk(irq == 1'b0 && evt_end, "R8 irq follows started clear", irq, 0);
        irq_en_clr = 2'b11;
        @(negedge clk);
        irq_en_clr = 2'b00;
        clear_events();

        run_txn(2, 0, 0, 0, 0, 1, 8'h00, 1);          // write-only, stray start, div change
        clear_events();

        run_txn(0, 0, 0, 1, 0, 3, 8'h00, 0);          // zero length
        clear_events();

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule